// File: doc/BRIEF.md
# Dual-strobe DRAM device decoder

This block is a synthesizable, clock-sampled functional model of the control side of an asynchronous DRAM that has one row strobe and two column strobes, one for each byte lane. A controller under test drives the strobes, write enable, output enable, the multiplexed address and the write data. The block classifies every memory cycle, latches row and column, stores data in a small internal array, drives per-lane output enables and reports each row refresh. A controller bench can therefore check its own strobe sequencing against it. Every input is sampled on the rising clock edge, and a level change between two samples stands in for a real strobe edge. Analog access delays are not modelled.

The two column strobes merge into one internal column strobe. It is active from the first lane that goes low until the last lane returns high. The ordering of the column strobe against a falling row strobe selects between an access with an addressed refresh and an internal-counter refresh.

Top module: `dram_dcas_dec`

## Requirements
- R1: The merged column strobe is active while either lane strobe is low. During a read, `dq_oe_o[0]` (low byte, lane strobe `lcas_ni`) and `dq_oe_o[1]` (high byte, `ucas_ni`) are each 1 only while that lane's own strobe is low, `oe_ni` is low and `we_ni` is high.
- R2: On a row-strobe fall with both column strobes high, `rfsh_o` pulses for one cycle with `rfsh_row_o` equal to the address pins. `kind_o` becomes 5 (row-only refresh), and an access may follow in the same cycle.
- R3: On a row-strobe fall with a column strobe low and no read held, the cycle is a counter refresh. `kind_o` becomes 6, `rfsh_o` pulses with the counter value, the address pins are ignored, and both output enables stay 0.
- R4: The refresh counter resets to 0. It advances by one after each counter refresh, including hidden refreshes, and wraps from 1023 to 0.
- R5: A column-strobe fall with the row strobe low and `we_ni` high starts a read. The column is latched, and `dout_o` holds the stored word from the next cycle on. `kind_o` becomes 1 if both lanes are low, or 2 if only one lane is low.
- R6: A column-strobe fall with `we_ni` low is an early write, and `kind_o` becomes 3. Both output enables stay 0 for the whole cycle, whatever `oe_ni` does.
- R7: If `we_ni` falls during a read, the cycle is a late write: `kind_o` becomes 4 and `din_i` is stored at the latched column.
- R8: A write changes only the byte lanes whose column strobe is low while the write is in effect. The other lane keeps its old value.
- R9: If the column strobe is held low after a read while the row strobe rises and falls again, the cycle is a hidden refresh. `kind_o` becomes 7, the refresh row comes from the counter, and the read data stays driven.
- R10: `oe_ni` high sampled at an edge turns both output enables off after that edge.
- R11: With the row strobe and both column strobes high, `kind_o` returns to 0 and both output enables are 0.
- R12: After reset, `kind_o` is 0, `dq_oe_o` is 0 and `rfsh_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| lcas_ni | input | 1 | Low-byte column strobe, active low |
| ucas_ni | input | 1 | High-byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data, valid per lane where `dq_oe_o` is set |
| dq_oe_o | output | 2 | Per-lane output drive: bit 0 low byte, bit 1 high byte |
| kind_o | output | 3 | Cycle class: 0 standby, 1 read, 2 byte read, 3 early write, 4 late write, 5 row-only refresh, 6 counter refresh, 7 hidden refresh |
| rfsh_o | output | 1 | One-cycle pulse: a row was refreshed |
| rfsh_row_o | output | ADDR_W | Row refreshed with `rfsh_o` |

## Verification
The assertions assume that strobe levels are held steady for at least one clock between transitions. They also assume that reset holds the row strobe high, so a fall seen right after reset is a real one. The stimulus changes inputs only on falling clock edges and moves through whole cycles that start and end in standby. Each strobe level lasts one or more clocks, so no transition hides between two samples.

// File: rtl/dram_dcas_pkg.sv
package dram_dcas_pkg;
  typedef enum logic [2:0] {
    CK_IDLE  = 3'd0,
    CK_READ  = 3'd1,
    CK_BREAD = 3'd2,
    CK_EWR   = 3'd3,
    CK_LWR   = 3'd4,
    CK_RONLY = 3'd5,
    CK_CBR   = 3'd6,
    CK_HID   = 3'd7
  } cyc_kind_e;
endpackage

// File: rtl/dcas_merge.sv
module dcas_merge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lcas_ni,
  input  logic       ucas_ni,
  output logic       cas_act_o,
  output logic       cas_fall_o,
  output logic [1:0] lane_low_o
);
  logic cas_q;
  assign lane_low_o = {~ucas_ni, ~lcas_ni};
  // first lane down opens, last lane up closes
  assign cas_act_o  = |lane_low_o;
  assign cas_fall_o = cas_act_o & ~cas_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cas_q <= 1'b0;
    else         cas_q <= cas_act_o;
endmodule

// File: rtl/rfsh_ctr.sv
module rfsh_ctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int IDX_W  = 6
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        wr_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]        ridx_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i)
      if (wr_i[g]) mem[widx_i] <= wdata_i[g*LANE_W +: LANE_W];
    assign rdata_o[g*LANE_W +: LANE_W] = mem[ridx_i];
  end
endmodule

// File: rtl/dram_dcas_dec.sv
module dram_dcas_dec
  import dram_dcas_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LANE_W    = 8,
  parameter int ARR_ROW_W = 3,
  parameter int ARR_COL_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ras_ni,
  input  logic                      lcas_ni,
  input  logic                      ucas_ni,
  input  logic                      we_ni,
  input  logic                      oe_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [2*LANE_W-1:0]       din_i,
  output logic [2*LANE_W-1:0]       dout_o,
  output logic [1:0]                dq_oe_o,
  output logic [2:0]                kind_o,
  output logic                      rfsh_o,
  output logic [ADDR_W-1:0]         rfsh_row_o
);
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = ARR_ROW_W + ARR_COL_W;

  logic             cas_act, cas_fall;
  logic [LANES-1:0] lane_low;
  logic [ADDR_W-1:0] ctr;
  logic [DATA_W-1:0] rdata;

  logic ras_q, row_ok_q, cbr_q, acc_q, read_q;
  logic [ARR_ROW_W-1:0] row_q;
  logic [ARR_COL_W-1:0] col_q;
  cyc_kind_e kind_q, kind_d;

  dcas_merge u_merge (
    .clk_i, .rst_ni, .lcas_ni, .ucas_ni,
    .cas_act_o(cas_act), .cas_fall_o(cas_fall), .lane_low_o(lane_low)
  );

  logic ras_fall, cbr_start, row_start, acc_ok, col_start, read_d, wr_en;
  logic [ARR_COL_W-1:0] col_now;
  logic [LANES-1:0] wr_lane, oe_d;

  assign ras_fall  = ras_q & ~ras_ni;
  assign cbr_start = ras_fall & cas_act;
  assign row_start = ras_fall & ~cas_act;
  assign acc_ok    = ~ras_ni & row_ok_q;
  assign col_start = cas_fall & acc_ok;
  assign col_now   = col_start ? addr_i[ARR_COL_W-1:0] : col_q;
  assign read_d    = col_start ? we_ni : (cas_act & read_q);
  assign wr_en     = acc_ok & ~we_ni & (col_start | acc_q);
  assign wr_lane   = {LANES{wr_en}} & lane_low;
  assign oe_d      = {LANES{read_d & ~oe_ni & we_ni}} & lane_low;

  rfsh_ctr #(.W(ADDR_W)) u_ctr (.clk_i, .rst_ni, .inc_i(cbr_start), .cnt_o(ctr));

  cell_array #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_arr (
    .clk_i,
    .wr_i   (wr_lane),
    .widx_i ({row_q, col_now}),
    .wdata_i(din_i),
    .ridx_i ({row_q, addr_i[ARR_COL_W-1:0]}),
    .rdata_o(rdata)
  );

  always_comb begin
    kind_d = kind_q;
    if (cbr_start)                       kind_d = read_q ? CK_HID : CK_CBR;
    else if (row_start)                  kind_d = CK_RONLY;
    else if (col_start)                  kind_d = !we_ni ? CK_EWR :
                                                  (&lane_low ? CK_READ : CK_BREAD);
    else if (read_q && !we_ni && acc_ok) kind_d = CK_LWR;
    else if (ras_ni && !cas_act)         kind_d = CK_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b1;
      row_ok_q   <= 1'b0;
      cbr_q      <= 1'b0;
      acc_q      <= 1'b0;
      read_q     <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      kind_q     <= CK_IDLE;
      dout_o     <= '0;
      dq_oe_o    <= '0;
      rfsh_o     <= 1'b0;
      rfsh_row_o <= '0;
    end else begin
      ras_q    <= ras_ni;
      row_ok_q <= row_start | (row_ok_q & ~ras_ni);
      cbr_q    <= cbr_start | (cbr_q & ~ras_ni);
      acc_q    <= col_start | (acc_q & cas_act);
      read_q   <= read_d;
      if (row_start) row_q <= addr_i[ARR_ROW_W-1:0];
      if (col_start) col_q <= addr_i[ARR_COL_W-1:0];
      if (col_start && we_ni) dout_o <= rdata;
      kind_q  <= kind_d;
      dq_oe_o <= oe_d;
      rfsh_o  <= ras_fall;
      if (ras_fall) rfsh_row_o <= cas_act ? ctr : addr_i;
    end
  end

  assign kind_o = kind_q;
endmodule

// File: rtl/dram_dcas_dec_chk.sv
module dram_dcas_dec_chk
  import dram_dcas_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              lcas_ni,
  input logic              ucas_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] dout_o,
  input logic [1:0]        dq_oe_o,
  input logic [2:0]        kind_o,
  input logic              rfsh_o,
  input logic [ADDR_W-1:0] rfsh_row_o
);
  logic [ADDR_W-1:0] next_ctr_row;
  logic ctr_evt;
  assign ctr_evt = rfsh_o && (kind_o == CK_CBR || kind_o == CK_HID);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      next_ctr_row <= '0;
    else if (ctr_evt) next_ctr_row <= rfsh_row_o + ADDR_W'(1);

  p_lane_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcas_ni |=> !dq_oe_o[0]);
  p_lane_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ucas_ni |=> !dq_oe_o[1]);
  p_fall_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_ni) |=> rfsh_o);
  p_no_stray_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ras_ni) |=> !rfsh_o);
  p_cbr_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == CK_CBR |-> dq_oe_o == 2'b00);
  p_ctr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_evt |-> rfsh_row_o == next_ctr_row);
  p_early_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == CK_EWR |-> dq_oe_o == 2'b00);
  p_oe_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> dq_oe_o == 2'b00);
  p_standby_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && lcas_ni && ucas_ni) |=> (dq_oe_o == 2'b00 && kind_o == CK_IDLE));
endmodule

bind dram_dcas_dec dram_dcas_dec_chk #(.ADDR_W(ADDR_W), .DATA_W(2*LANE_W)) u_chk (.*);

// File: tb/dram_dcas_dec_bench.sv
module dram_dcas_dec_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_ni = 1'b1, lcas_ni = 1'b1, ucas_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [9:0]  addr_i = '0;
  logic [15:0] din_i = '0;
  logic [15:0] dout_o;
  logic [1:0]  dq_oe_o;
  logic [2:0]  kind_o;
  logic        rfsh_o;
  logic [9:0]  rfsh_row_o;

  dram_dcas_dec u_dram_dcas_dec (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int          due;
    int          fld;
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam int F_KIND = 0, F_OE = 1, F_DOUT = 2, F_RF = 3, F_ROW = 4;

  function automatic logic [15:0] field(int f);
    case (f)
      F_KIND:  return 16'(kind_o);
      F_OE:    return 16'(dq_oe_o);
      F_DOUT:  return dout_o;
      F_RF:    return 16'(rfsh_o);
      default: return 16'(rfsh_row_o);
    endcase
  endfunction

  // monitor: compare queued expectations one step after the edge
  always begin
    @(posedge clk_i);
    #1;
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [15:0] a;
      e = q.pop_front();
      a = field(e.fld);
      n_chk++;
      if (a !== e.val) begin
        n_bad++;
        $display("FAIL %s field=%0d actual=%h expected=%h", e.req, e.fld, a, e.val);
      end
    end
  end

  task automatic drv(input logic r, l, u, w, o, input logic [9:0] a, input logic [15:0] d);
    ras_ni = r; lcas_ni = l; ucas_ni = u; we_ni = w; oe_ni = o; addr_i = a; din_i = d;
  endtask
  task automatic expect_(input int f, input logic [15:0] v, input string req);
    q.push_back('{cyc + 1, f, v, req});
  endtask
  task automatic tick;
    @(negedge clk_i);
  endtask
  task automatic idle(input bit chk);
    drv(1, 1, 1, 1, 1, '0, '0);
    if (chk) begin
      expect_(F_KIND, 16'd0, "R11");
      expect_(F_OE, 16'd0, "R11");
    end
    tick();
  endtask
  task automatic cbr(input logic [9:0] row, input bit chk);
    drv(1, 0, 1, 1, 1, '0, '0); tick();
    drv(0, 0, 1, 1, 0, 10'h2AA, '0);
    if (chk) begin
      expect_(F_RF, 16'd1, "R4");
      expect_(F_ROW, 16'(row), "R4");
    end
    tick();
    idle(0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    drv(1, 1, 1, 1, 1, '0, '0);
    expect_(F_KIND, 16'd0, "R12");
    expect_(F_OE, 16'd0, "R12");
    expect_(F_RF, 16'd0, "R12");
    tick();

    // early write row 5 col 3
    drv(0, 1, 1, 1, 1, 10'd5, '0);
    expect_(F_RF, 16'd1, "R2"); expect_(F_ROW, 16'd5, "R2"); expect_(F_KIND, 16'd5, "R2");
    tick();
    drv(0, 0, 0, 0, 0, 10'd3, 16'hA5C3);
    expect_(F_KIND, 16'd3, "R6"); expect_(F_OE, 16'd0, "R6"); expect_(F_RF, 16'd0, "R2");
    tick();
    drv(0, 0, 0, 0, 0, 10'd3, 16'hA5C3);
    expect_(F_OE, 16'd0, "R6");
    tick();
    idle(1);

    // word read back
    drv(0, 1, 1, 1, 1, 10'd5, '0); tick();
    drv(0, 0, 0, 1, 0, 10'd3, '0);
    expect_(F_KIND, 16'd1, "R5"); expect_(F_OE, 16'd3, "R1"); expect_(F_DOUT, 16'hA5C3, "R5");
    tick();
    drv(0, 0, 0, 1, 1, 10'd3, '0);
    expect_(F_OE, 16'd0, "R10");
    tick();
    drv(0, 0, 1, 1, 0, 10'd3, '0);
    expect_(F_OE, 16'd1, "R1");
    tick();
    idle(1);

    // byte write, high lane only
    drv(0, 1, 1, 1, 1, 10'd5, '0); tick();
    drv(0, 1, 0, 0, 1, 10'd3, 16'h1234);
    expect_(F_KIND, 16'd3, "R6");
    tick();
    idle(0);
    // low-lane byte read
    drv(0, 1, 1, 1, 1, 10'd5, '0); tick();
    drv(0, 0, 1, 1, 0, 10'd3, '0);
    expect_(F_KIND, 16'd2, "R5"); expect_(F_OE, 16'd1, "R1"); expect_(F_DOUT, 16'h12C3, "R8");
    tick();
    idle(1);

    // late write row 2 col 6
    drv(0, 1, 1, 1, 1, 10'd2, '0); tick();
    drv(0, 0, 0, 1, 0, 10'd6, '0);
    expect_(F_KIND, 16'd1, "R5");
    tick();
    drv(0, 0, 0, 0, 1, 10'd6, 16'hBEEF);
    expect_(F_KIND, 16'd4, "R7"); expect_(F_OE, 16'd0, "R7");
    tick();
    idle(0);
    drv(0, 1, 1, 1, 1, 10'd2, '0); tick();
    drv(0, 0, 0, 1, 0, 10'd6, '0);
    expect_(F_DOUT, 16'hBEEF, "R7");
    tick();
    idle(0);

    // row-only refresh
    drv(0, 1, 1, 1, 1, 10'h3F7, '0);
    expect_(F_RF, 16'd1, "R2"); expect_(F_ROW, 16'h3F7, "R2"); expect_(F_KIND, 16'd5, "R2");
    tick();
    drv(0, 1, 1, 1, 0, 10'h3F7, '0);
    expect_(F_KIND, 16'd5, "R2"); expect_(F_OE, 16'd0, "R2"); expect_(F_RF, 16'd0, "R2");
    tick();
    idle(1);

    // counter refresh: address ignored, outputs stay off
    drv(1, 0, 1, 1, 0, '0, '0); tick();
    drv(0, 0, 1, 1, 0, 10'h155, '0);
    expect_(F_KIND, 16'd6, "R3"); expect_(F_ROW, 16'd0, "R3"); expect_(F_OE, 16'd0, "R3");
    tick();
    idle(1);
    cbr(10'd1, 1);

    // hidden refresh after read of row 4 col 1
    drv(0, 1, 1, 1, 1, 10'd4, '0); tick();
    drv(0, 0, 0, 0, 1, 10'd1, 16'h5A5A); tick();
    idle(0);
    drv(0, 1, 1, 1, 1, 10'd4, '0); tick();
    drv(0, 0, 0, 1, 0, 10'd1, '0);
    expect_(F_DOUT, 16'h5A5A, "R9");
    tick();
    drv(1, 0, 0, 1, 0, 10'd1, '0);
    expect_(F_OE, 16'd3, "R9");
    tick();
    drv(0, 0, 0, 1, 0, 10'h0AB, '0);
    expect_(F_KIND, 16'd7, "R9"); expect_(F_ROW, 16'd2, "R9");
    expect_(F_OE, 16'd3, "R9"); expect_(F_DOUT, 16'h5A5A, "R9");
    tick();
    idle(1);

    // run counter to wrap
    for (int i = 3; i < 1024; i++) cbr(10'(i), i >= 1021);
    cbr(10'd0, 1);

    tick(); tick(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule